// File: doc/BRIEF.md
# Single-Precision Mantissa Rounder

This block turns a wide intermediate floating-point result into a 24-bit significand with its leading one included. It is the last step of an arithmetic pipeline. The caller supplies a sign, a biased exponent carried with two guard bits of headroom, and an unsigned mantissa with two integer bits. The mantissa is in [1,4), and eight low-order bits lie below the single-precision LSB. The caller also picks one of four rounding modes.

The block first brings a mantissa in [2,4) down into [1,2) and bumps the exponent. It then derives the LSB, round and sticky bits and decides from the mode and sign whether to add one unit at the LSB. A carry out of the significand is renormalised. The result is registered once, so it appears one clock after the inputs are presented. Flags report an out-of-range exponent and a result that differs from its input. Denormals and special encodings are left to other logic.

Top module: `rnd_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Outputs reflect the inputs sampled at the previous rising edge of `clk`.
- R3: When `mant_in[32]` (weight 2) is set, the mantissa is shifted right by one and the exponent raised by one before rounding. The bit shifted out joins the sticky bit.
- R4: After prenormalisation, bit 31 has weight 1 and the 24 kept bits are [31:8]. The LSB is bit 8 and the round bit is bit 7. The sticky bit is the OR of bits [6:0]. `inexact_out` is round OR sticky.
- R5: Mode 00 (nearest, ties to even) adds one when round is set and either sticky or the LSB is set.
- R6: Mode 01 (toward zero) never adds; the kept bits pass through unchanged.
- R7: Mode 10 (toward +inf) adds one when the sign is 0 and round or sticky is set.
- R8: Mode 11 (toward -inf) adds one when the sign is 1 and round or sticky is set.
- R9: If the addition carries out of 24 bits, the result is 0x800000 and the exponent rises by one more.
- R10: `ovf_out` is set when the final exponent is 255 or more. `unf_out` is set when it is 0 or less. `exp_out` is the low 8 bits of the final exponent. The two flags are never set together.
- R11: For any input mantissa of at least 1, `mant_out[23]` is 1.
- R12: `sign_out` equals the registered `sign_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sign_in | input | 1 | Sign of the value |
| exp_in | input | 10 | Biased exponent, two's complement |
| mant_in | input | 33 | Mantissa, 2 integer bits, 31 fraction bits |
| mode_in | input | 2 | Rounding mode |
| mant_out | output | 24 | Rounded significand with leading one |
| exp_out | output | 8 | Final exponent, low 8 bits |
| sign_out | output | 1 | Registered sign |
| ovf_out | output | 1 | Exponent overflow |
| unf_out | output | 1 | Exponent underflow |
| inexact_out | output | 1 | Rounding discarded nonzero bits |

## Verification
Directed vectors sit exactly on a halfway point with an even and an odd LSB. This separates the tie rule from plain round-half-up. An all-ones kept field under an upward mode forces the carry renormalisation. A [2,4) input whose only nonzero discarded bit is the one lost in prenormalisation shows whether that bit reaches sticky. Exponents placed at 254, 255 and 0 probe both flag boundaries. Random vectors across all modes, both signs and both mantissa ranges are compared with a reference that rounds by integer division rather than by bit selection.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_ZERO      = 2'b01,
        RM_POS       = 2'b10,
        RM_NEG       = 2'b11
    } rmode_e;
endpackage

// File: rtl/rnd_prenorm.sv
module rnd_prenorm #(
    parameter int MW = 33,
    parameter int EW = 10
) (
    input  logic [MW-1:0]        mant,
    input  logic signed [EW-1:0] exp_i,
    output logic [MW-2:0]        norm,
    output logic                 lost,
    output logic signed [EW-1:0] exp_o
);
    logic wide;
    always_comb begin
        wide  = mant[MW-1];
        norm  = wide ? mant[MW-1:1] : mant[MW-2:0];
        lost  = wide & mant[0];
        exp_o = exp_i + EW'(wide);
    end
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
#(
    parameter int NW = 32,
    parameter int XW = 8
) (
    input  logic [NW-1:0]    norm,
    input  logic             lost,
    input  logic             sign,
    input  rmode_e           mode,
    output logic [NW-XW-1:0] kept,
    output logic             inc,
    output logic             inexact
);
    logic lsb, rbit, sbit;
    always_comb begin
        kept    = norm[NW-1:XW];
        lsb     = norm[XW];
        rbit    = norm[XW-1];
        sbit    = (|norm[XW-2:0]) | lost;
        inexact = rbit | sbit;
        unique case (mode)
            RM_NEAR_EVEN: inc = rbit & (sbit | lsb);
            RM_ZERO:      inc = 1'b0;
            RM_POS:       inc = ~sign & inexact;
            RM_NEG:       inc = sign & inexact;
            default:      inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/rnd_post.sv
module rnd_post #(
    parameter int SW    = 24,
    parameter int EW    = 10,
    parameter int EXP_W = 8
) (
    input  logic [SW-1:0]        kept,
    input  logic                 inc,
    input  logic signed [EW-1:0] exp_i,
    output logic [SW-1:0]        mant,
    output logic [EXP_W-1:0]     exp_o,
    output logic                 ovf,
    output logic                 unf
);
    localparam logic signed [EW-1:0] EXP_TOP = EW'((1 << EXP_W) - 1);
    logic [SW:0]          sum;
    logic signed [EW-1:0] exp_f;
    always_comb begin
        sum   = {1'b0, kept} + {{SW{1'b0}}, inc};
        mant  = sum[SW] ? sum[SW:1] : sum[SW-1:0];
        exp_f = exp_i + EW'(sum[SW]);
        exp_o = exp_f[EXP_W-1:0];
        ovf   = exp_f >= EXP_TOP;
        unf   = exp_f <= 0;
    end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int XTRA_W = 8,
    parameter int EXP_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sign_in,
    input  logic [EXP_W+1:0]      exp_in,
    input  logic [FRAC_W+XTRA_W+1:0] mant_in,
    input  logic [1:0]            mode_in,
    output logic [FRAC_W:0]       mant_out,
    output logic [EXP_W-1:0]      exp_out,
    output logic                  sign_out,
    output logic                  ovf_out,
    output logic                  unf_out,
    output logic                  inexact_out
);
    localparam int MW = FRAC_W + XTRA_W + 2;
    localparam int NW = MW - 1;
    localparam int EW = EXP_W + 2;
    localparam int SW = FRAC_W + 1;

    logic [NW-1:0]        norm;
    logic                 lost, inc, inexact, ovf, unf;
    logic signed [EW-1:0] exp_pre;
    logic [SW-1:0]        kept, mant_r;
    logic [EXP_W-1:0]     exp_r;
    rmode_e               mode;

    assign mode = rmode_e'(mode_in);

    rnd_prenorm #(.MW(MW), .EW(EW)) u_pre (
        .mant(mant_in), .exp_i($signed(exp_in)),
        .norm(norm), .lost(lost), .exp_o(exp_pre)
    );

    rnd_decide #(.NW(NW), .XW(XTRA_W)) u_dec (
        .norm(norm), .lost(lost), .sign(sign_in), .mode(mode),
        .kept(kept), .inc(inc), .inexact(inexact)
    );

    rnd_post #(.SW(SW), .EW(EW), .EXP_W(EXP_W)) u_post (
        .kept(kept), .inc(inc), .exp_i(exp_pre),
        .mant(mant_r), .exp_o(exp_r), .ovf(ovf), .unf(unf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mant_out    <= '0;
            exp_out     <= '0;
            sign_out    <= 1'b0;
            ovf_out     <= 1'b0;
            unf_out     <= 1'b0;
            inexact_out <= 1'b0;
        end else begin
            mant_out    <= mant_r;
            exp_out     <= exp_r;
            sign_out    <= sign_in;
            ovf_out     <= ovf;
            unf_out     <= unf;
            inexact_out <= inexact;
        end
    end
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
    parameter int FRAC_W = 23,
    parameter int XTRA_W = 8,
    parameter int EXP_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sign_in,
    input logic [EXP_W+1:0]          exp_in,
    input logic [FRAC_W+XTRA_W+1:0]  mant_in,
    input logic [1:0]                mode_in,
    input logic [FRAC_W:0]           mant_out,
    input logic [EXP_W-1:0]          exp_out,
    input logic                      sign_out,
    input logic                      ovf_out,
    input logic                      unf_out,
    input logic                      inexact_out
);
    localparam int TOP = FRAC_W + XTRA_W + 1;

    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mant_in[TOP] | mant_in[TOP-1])) |-> mant_out[FRAC_W]); // R11

    AST_ZERO_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_in == 2'b01 && !mant_in[TOP]))
        |-> (mant_out == $past(mant_in[TOP-1:XTRA_W]) && exp_out == $past(exp_in[EXP_W-1:0]))); // R6

    AST_POS_NEG_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_in == 2'b10 && sign_in && !mant_in[TOP]))
        |-> mant_out == $past(mant_in[TOP-1:XTRA_W])); // R7

    AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!mant_in[TOP] && mant_in[XTRA_W-1:0] == '0)) |-> !inexact_out); // R4

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_out && unf_out)); // R10

    AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sign_out == $past(sign_in)); // R12
endmodule

bind rnd_unit rnd_unit_chk #(.FRAC_W(FRAC_W), .XTRA_W(XTRA_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/sim_rnd_unit.sv
module sim_rnd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sign_in = 1'b0;
    logic [9:0]  exp_in = '0;
    logic [32:0] mant_in = '0;
    logic [1:0]  mode_in = '0;
    logic [23:0] mant_out;
    logic [7:0]  exp_out;
    logic        sign_out, ovf_out, unf_out, inexact_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rnd_unit u0 (
        .clk(clk), .rst_n(rst_n), .sign_in(sign_in), .exp_in(exp_in),
        .mant_in(mant_in), .mode_in(mode_in), .mant_out(mant_out),
        .exp_out(exp_out), .sign_out(sign_out), .ovf_out(ovf_out),
        .unf_out(unf_out), .inexact_out(inexact_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: round by integer division by the unit at the kept LSB.
    task automatic run(input bit s, input int e, input longint m, input int md, input string tag);
        longint unit, q, r, half;
        int ef, sh;
        bit inc;
        sh   = m[32] ? 1 : 0;
        ef   = e + sh;
        unit = longint'(1) << (8 + sh);
        q    = m / unit;
        r    = m % unit;
        half = unit / 2;
        case (md)
            0: inc = (r > half) || (r == half && q[0]);
            1: inc = 0;
            2: inc = !s && r != 0;
            default: inc = s && r != 0;
        endcase
        q = q + longint'(inc);
        if (q == (longint'(1) << 24)) begin
            q  = longint'(1) << 23;
            ef = ef + 1;
        end
        @(negedge clk);
        sign_in = s; exp_in = e[9:0]; mant_in = m[32:0]; mode_in = md[1:0];
        @(negedge clk);
        check({tag, " R2 R5 R6 R7 R8 R9 mant"}, longint'(mant_out), q);
        check({tag, " R3 R9 R10 exp"}, longint'(exp_out), longint'(ef & 255));
        check({tag, " R10 ovf"}, longint'(ovf_out), longint'(ef >= 255));
        check({tag, " R10 unf"}, longint'(unf_out), longint'(ef <= 0));
        check({tag, " R4 inexact"}, longint'(inexact_out), longint'(r != 0));
        check({tag, " R12 sign"}, longint'(sign_out), longint'(s));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234abcd));
        sign_in = 1'b1; exp_in = 10'd77; mant_in = '1; mode_in = 2'b10;
        #23;
        // R1: outputs held at zero during reset
        check("R1 mant", longint'(mant_out), 0);
        check("R1 flags", longint'({exp_out, sign_out, ovf_out, unf_out, inexact_out}), 0);
        @(negedge clk); rst_n = 1'b1;

        // Ties: odd LSB rounds up, even LSB stays (R5)
        run(0, 100, 33'h0_8000_0180, 0, "tie-odd");
        run(0, 100, 33'h0_8000_0080, 0, "tie-even");
        run(1, 100, 33'h0_8000_0081, 0, "above-half");
        // Directed modes with one discarded bit (R6 R7 R8)
        run(1, 50, 33'h0_8000_0001, 1, "rtz-neg");
        run(0, 50, 33'h0_8000_0001, 2, "up-pos");
        run(1, 50, 33'h0_8000_0001, 2, "up-neg");
        run(1, 50, 33'h0_8000_0001, 3, "down-neg");
        run(0, 50, 33'h0_8000_0001, 3, "down-pos");
        // Carry out of the significand (R9)
        run(0, 10, 33'h0_FFFF_FFFF, 2, "carry");
        // Prenormalisation: only the shifted-out bit is nonzero (R3)
        run(0, 20, 33'h1_0000_0001, 2, "lost-bit");
        run(0, 20, 33'h1_0000_0000, 0, "wide-exact");
        // Exponent boundaries (R10)
        run(0, 254, 33'h0_FFFF_FFFF, 0, "ovf-carry");
        run(0, 254, 33'h0_8000_0000, 0, "max-ok");
        run(0, 0, 33'h0_8000_0000, 0, "unf");
        run(1, -1, 33'h1_FFFF_FFFF, 3, "unf-to-zero");
        run(0, 1, 33'h0_8000_0000, 0, "min-ok");

        for (int i = 0; i < 3000; i++) begin
            longint m;
            int e;
            m = {31'h0, $urandom_range(1, 0), $urandom};
            if (m[32:31] == 2'b00) m[31] = 1'b1;
            if ($urandom_range(3, 0) == 0) m[7:0] = 8'h80;
            e = int'($urandom_range(261, 0)) - 3;
            run($urandom_range(1, 0), e, m, int'($urandom_range(3, 0)), "random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule